// File: doc/BRIEF.md
# Codec Link Halt and Wake Controller

This block sits on the codec side of a serial audio link and decides when the codec's bit clock runs. While the clock runs, it follows the controller's frames. Each frame is 256 bit times long. A rising edge on the frame marker input opens a new frame. The block picks up the three leading tag bits of the frame header, the read/write flag, the register index of the command slot, and the 16-bit word of the data slot. A valid write that sets the power-down flag in the power-control register stops the bit clock and pulls the serial return data low. A valid write to the reset register asks the register file to return to its defaults, keeping the serial configuration register.

While the clock is stopped, the frame marker is no longer sampled as part of a frame. It is taken as an asynchronous wake request instead. It passes through a synchronizer, and its high time is measured with the local oscillator clock. A high level held for at least `WARM_CYC` oscillator cycles, followed by a release, is a warm wake. The clock starts again and no register is touched. Shorter pulses are ignored. The active-low power-on reset is asynchronous. It restarts the clock at once and the register file takes it directly for a cold clear. After any wake or cold reset, the codec-ready flag stays low until `RDY_FRAMES` frame starts have been seen.

The controller has four states. WAKE means the clock runs and the block is not ready yet. RUN means the clock runs and the block is ready. HALT means the clock is stopped and the marker is being measured. ARMED means the clock is stopped and a long enough pulse has been seen. The transitions are:
- halt_req: WAKE or RUN to HALT.
- ready_reached: WAKE to RUN.
- width_met: HALT to ARMED.
- marker_release: ARMED to WAKE.
- cold reset: any state to WAKE.

Top module: `ac_link_pm`

## Requirements
- R1: A frame marker rise sampled on a running clock edge marks bit position 0 of a frame. Positions 1 to 255 follow on the next edges. Command fields are read only at these positions, so the same bits placed one position late do not form a command.
- R2: A command is accepted when both of these hold:
  - It is a write to index 0x26 with data bit 12 set.
  - The bits are the tags at positions 0, 1 and 2, the flag at position 16, index MSB-first at positions 17 to 23, and data MSB-first at positions 36 to 51.

  Its acceptance drives `bclk_en` and `din_en` low after the edge that samples position 56. They then stay low whatever `cmd_sdat` does.
- R3: A command counts only when all three tags are 1 and the read/write flag at position 16 is 0 (write). A read, or a frame with any tag clear, does not stop the clock.
- R4: A write to index 0x26 with data bit 12 clear leaves the clock running.
- R5: A write to index 0x00 gives a `clr_regs` pulse exactly one cycle long, after the edge that samples position 56. The clock keeps running.
- R6: While halted, a `frame_mark` high level of at least `WARM_CYC` consecutive oscillator cycles restarts the clock once the marker is released. With `SYNC_STAGES`=2 this happens on the third edge after the marker falls. The clock never restarts while the marker is still high.
- R7: While halted, a marker pulse shorter than `WARM_CYC` cycles is ignored and the clock stays stopped.
- R8: `por_n` low asynchronously forces `bclk_en` and `din_en` high and `codec_ready` low, with no clock edge needed.
- R9: `codec_ready` is low after a cold reset or a warm wake. It rises after the edge that samples the `RDY_FRAMES`-th frame start, and it is low whenever the clock is stopped.
- R10: A halt or a warm wake never raises `clr_regs`, so register contents survive power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local oscillator clock; one cycle per bit time while the link runs |
| por_n | input | 1 | Asynchronous active-low cold reset |
| frame_mark | input | 1 | Frame marker from the controller; asynchronous wake request while halted |
| cmd_sdat | input | 1 | Serial command stream from the controller, one bit per cycle |
| bclk_en | output | 1 | Bit clock gate enable |
| din_en | output | 1 | Serial return data drive enable; low holds the line low |
| codec_ready | output | 1 | Codec-ready flag for the return frame header |
| clr_regs | output | 1 | One-cycle request to restore register defaults except serial configuration |

## Verification
The bench builds the block with `WARM_CYC`=8, `RDY_FRAMES`=2 and `SYNC_STAGES`=2. With a wake width of eight cycles, both sides of the threshold can be tested: a seven-cycle pulse and an eight-cycle pulse. The wake latency through the synchronizer can also be counted edge by edge. A two-frame ready delay lets the bench see the flag stay low through one whole frame and rise on the next frame start, inside a short run.

// File: rtl/ac_pm_pkg.sv
package ac_pm_pkg;

    typedef enum logic [1:0] {
        ST_WAKE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2,
        ST_ARMED = 2'd3
    } pm_state_e;

    localparam int FRAME_LEN   = 256;
    localparam int TAG_COUNT   = 3;
    localparam int POS_RW      = 16;
    localparam int IDX_W       = 7;
    localparam int POS_IDX_LO  = 17;
    localparam int DATA_W      = 16;
    localparam int POS_DATA_LO = 36;
    localparam int POS_DECODE  = 55;
    localparam int HALT_BIT    = 12;

    localparam logic [IDX_W-1:0] REG_PWR_IDX = 7'h26;
    localparam logic [IDX_W-1:0] REG_RST_IDX = 7'h00;

endpackage

// File: rtl/ac_slot_decode.sv
module ac_slot_decode
    import ac_pm_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_LEN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      mark,
    input  logic                      sdat,
    output logic                      frame_start,
    output logic                      cmd_valid,
    output logic [IDX_W-1:0]          cmd_idx,
    output logic [DATA_W-1:0]         cmd_data
);

    localparam int POS_W = $clog2(FRAME_BITS);

    logic                  mark_prev;
    logic                  locked;
    logic [POS_W-1:0]      pos_q;
    logic [POS_W-1:0]      cur_pos;
    logic                  active;
    logic [TAG_COUNT-1:0]  tags_q;
    logic                  rw_q;
    logic [IDX_W-1:0]      idx_q;
    logic [DATA_W-1:0]     data_q;
    logic                  in_idx;
    logic                  in_data;

    assign frame_start = run && mark && !mark_prev;
    assign cur_pos     = frame_start ? '0 : pos_q;
    assign active      = locked || frame_start;
    assign in_idx      = (cur_pos >= POS_W'(POS_IDX_LO)) &&
                         (cur_pos <  POS_W'(POS_IDX_LO + IDX_W));
    assign in_data     = (cur_pos >= POS_W'(POS_DATA_LO)) &&
                         (cur_pos <  POS_W'(POS_DATA_LO + DATA_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_prev <= 1'b0;
            locked    <= 1'b0;
            pos_q     <= '0;
            tags_q    <= '0;
            rw_q      <= 1'b1;
            idx_q     <= '0;
            data_q    <= '0;
            cmd_valid <= 1'b0;
        end else if (!run) begin
            locked    <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            mark_prev <= mark;
            cmd_valid <= 1'b0;
            pos_q     <= (cur_pos == POS_W'(FRAME_BITS - 1)) ? '0 : cur_pos + 1'b1;
            if (frame_start) begin
                locked <= 1'b1;
            end
            if (active) begin
                for (int t = 0; t < TAG_COUNT; t++) begin
                    if (cur_pos == POS_W'(t)) begin
                        tags_q[t] <= sdat;
                    end
                end
                if (cur_pos == POS_W'(POS_RW)) begin
                    rw_q <= sdat;
                end
                if (in_idx) begin
                    idx_q <= {idx_q[IDX_W-2:0], sdat};
                end
                if (in_data) begin
                    data_q <= {data_q[DATA_W-2:0], sdat};
                end
                if (cur_pos == POS_W'(POS_DECODE)) begin
                    cmd_valid <= (&tags_q) && !rw_q;
                end
            end
        end
    end

    assign cmd_idx  = idx_q;
    assign cmd_data = data_q;

    // R3: an accepted command is reported for a single cycle per frame
    a_r3_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/ac_wake_detect.sv
module ac_wake_detect #(
    parameter int WARM_CYC    = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic mark_async,
    output logic mark_lvl,
    output logic width_met
);

    localparam int CNT_W = $clog2(WARM_CYC + 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [CNT_W-1:0]       hi_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain[0] <= mark_async;
                end
            end
        end else begin : g_sync_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[SYNC_STAGES-2:0], mark_async};
                end
            end
        end
    endgenerate

    assign mark_lvl = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!halted || !mark_lvl) begin
            hi_cnt <= '0;
        end else if (hi_cnt != CNT_W'(WARM_CYC - 1)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign width_met = halted && mark_lvl && (hi_cnt == CNT_W'(WARM_CYC - 1));

    // R7: the width counter saturates below the wake threshold
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= CNT_W'(WARM_CYC - 1));

endmodule

// File: rtl/ac_pm_fsm.sv
module ac_pm_fsm
    import ac_pm_pkg::*;
#(
    parameter int RDY_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              width_met,
    input  logic              mark_lvl,
    output logic              bclk_en,
    output logic              din_en,
    output logic              ready,
    output logic              clr_regs
);

    localparam int RC_W = $clog2(RDY_FRAMES + 1);

    pm_state_e        st_q;
    pm_state_e        st_d;
    logic [RC_W-1:0]  rdy_cnt;
    logic             halt_req;
    logic             regrst_req;
    logic             ready_reached;

    assign halt_req      = cmd_valid && (cmd_idx == REG_PWR_IDX) && cmd_data[HALT_BIT];
    assign regrst_req    = cmd_valid && (cmd_idx == REG_RST_IDX);
    assign ready_reached = frame_start && (rdy_cnt == RC_W'(RDY_FRAMES - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAKE: begin
                if (halt_req) begin
                    st_d = ST_HALT;
                end else if (ready_reached) begin
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (halt_req) begin
                    st_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (width_met) begin
                    st_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!mark_lvl) begin
                    st_d = ST_WAKE;
                end
            end
            default: st_d = ST_WAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WAKE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_cnt  <= '0;
            clr_regs <= 1'b0;
        end else begin
            clr_regs <= regrst_req;
            if (st_q != ST_WAKE) begin
                rdy_cnt <= '0;
            end else if (frame_start && !ready_reached) begin
                rdy_cnt <= rdy_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        bclk_en = (st_q == ST_WAKE) || (st_q == ST_RUN);
        din_en  = bclk_en;
        ready   = (st_q == ST_RUN);
    end

    // R2: an accepted halt command stops the clock on the next edge
    a_r2_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !bclk_en);

    // R6: the clock stays stopped while the synchronized marker is high
    a_r6_no_wake_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_en && mark_lvl) |=> !bclk_en);

    // R5: a register reset request lasts exactly one cycle
    a_r5_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        clr_regs |=> !clr_regs);

    // R9: readiness is only shown with a running clock
    a_r9_ready_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> bclk_en);

endmodule

// File: rtl/ac_link_pm.sv
module ac_link_pm
    import ac_pm_pkg::*;
#(
    parameter int WARM_CYC    = 25,
    parameter int RDY_FRAMES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic frame_mark,
    input  logic cmd_sdat,
    output logic bclk_en,
    output logic din_en,
    output logic codec_ready,
    output logic clr_regs
);

    logic              frame_start;
    logic              cmd_valid;
    logic [IDX_W-1:0]  cmd_idx;
    logic [DATA_W-1:0] cmd_data;
    logic              mark_lvl;
    logic              width_met;

    ac_slot_decode #(
        .FRAME_BITS (FRAME_LEN)
    ) u_decode (
        .clk         (clk),
        .rst_n       (por_n),
        .run         (bclk_en),
        .mark        (frame_mark),
        .sdat        (cmd_sdat),
        .frame_start (frame_start),
        .cmd_valid   (cmd_valid),
        .cmd_idx     (cmd_idx),
        .cmd_data    (cmd_data)
    );

    ac_wake_detect #(
        .WARM_CYC    (WARM_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_wake (
        .clk        (clk),
        .rst_n      (por_n),
        .halted     (!bclk_en),
        .mark_async (frame_mark),
        .mark_lvl   (mark_lvl),
        .width_met  (width_met)
    );

    ac_pm_fsm #(
        .RDY_FRAMES (RDY_FRAMES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (por_n),
        .frame_start (frame_start),
        .cmd_valid   (cmd_valid),
        .cmd_idx     (cmd_idx),
        .cmd_data    (cmd_data),
        .width_met   (width_met),
        .mark_lvl    (mark_lvl),
        .bclk_en     (bclk_en),
        .din_en      (din_en),
        .ready       (codec_ready),
        .clr_regs    (clr_regs)
    );

endmodule

// File: tb/ac_link_pm_bench.sv
module ac_link_pm_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WARM       = 8;
    localparam int RDY        = 2;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic frame_mark = 1'b0;
    logic cmd_sdat = 1'b0;
    logic bclk_en, din_en, codec_ready, clr_regs;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ac_link_pm #(
        .WARM_CYC    (WARM),
        .RDY_FRAMES  (RDY),
        .SYNC_STAGES (2)
    ) u_ac_link_pm (
        .clk         (clk),
        .por_n       (por_n),
        .frame_mark  (frame_mark),
        .cmd_sdat    (cmd_sdat),
        .bclk_en     (bclk_en),
        .din_en      (din_en),
        .codec_ready (codec_ready),
        .clr_regs    (clr_regs)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_frame(input logic [2:0] tg, input logic rw,
                                              input logic [6:0] idx, input logic [15:0] d);
        logic [255:0] f;
        f = '0;
        f[0] = tg[0];
        f[1] = tg[1];
        f[2] = tg[2];
        f[16] = rw;
        for (int i = 0; i < 7; i++) f[17 + i] = idx[6 - i];
        for (int i = 0; i < 16; i++) f[36 + i] = d[15 - i];
        return f;
    endfunction

    task automatic send_range(input logic [255:0] f, input int lo, input int hi);
        for (int p = lo; p < hi; p++) begin
            @(negedge clk);
            frame_mark = (p < 16);
            cmd_sdat   = f[p];
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_mark = 1'b0;
            cmd_sdat   = 1'b0;
        end
    endtask

    task automatic t_reset();
        por_n = 1'b0;
        repeat (3) settle();
        chk("R8", "bclk_en in reset", bclk_en, 1'b1);
        chk("R8", "din_en in reset", din_en, 1'b1);
        chk("R9", "ready in reset", codec_ready, 1'b0);
        chk("R8", "clr_regs in reset", clr_regs, 1'b0);
        @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic t_ready(input string req);
        logic [255:0] f0;
        f0 = mk_frame(3'b000, 1'b0, 7'h00, 16'h0000);
        send_range(f0, 0, 256);
        settle();
        chk(req, "ready after one frame", codec_ready, 1'b0);
        send_range(f0, 0, 1);
        settle();
        chk(req, "ready at second frame start", codec_ready, 1'b1);
        send_range(f0, 1, 256);
    endtask

    task automatic t_no_halt(input string req, input logic [255:0] f);
        send_range(f, 0, 57);
        settle();
        chk(req, "clock kept after decode", bclk_en, 1'b1);
        chk(req, "no clear request", clr_regs, 1'b0);
        send_range(f, 57, 256);
        settle();
        chk(req, "clock kept at frame end", bclk_en, 1'b1);
    endtask

    task automatic t_regrst();
        logic [255:0] f;
        f = mk_frame(3'b111, 1'b0, 7'h00, 16'hFFFF);
        send_range(f, 0, 57);
        settle();
        chk("R5", "clr_regs pulse", clr_regs, 1'b1);
        chk("R5", "clock kept", bclk_en, 1'b1);
        send_range(f, 57, 58);
        settle();
        chk("R5", "clr_regs one cycle", clr_regs, 1'b0);
        send_range(f, 58, 256);
    endtask

    task automatic t_halt();
        logic [255:0] f;
        f = mk_frame(3'b111, 1'b0, 7'h26, 16'h1000);
        send_range(f, 0, 56);
        settle();
        chk("R2", "clock before position 56", bclk_en, 1'b1);
        send_range(f, 56, 57);
        settle();
        chk("R2", "bclk_en halted", bclk_en, 1'b0);
        chk("R2", "din_en halted", din_en, 1'b0);
        chk("R9", "ready low halted", codec_ready, 1'b0);
        chk("R10", "no clear on halt", clr_regs, 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            frame_mark = 1'b0;
            cmd_sdat   = i[0];
        end
        settle();
        chk("R2", "clock stays stopped", bclk_en, 1'b0);
        idle(1);
    endtask

    task automatic t_short();
        for (int i = 0; i < WARM - 1; i++) begin
            @(negedge clk);
            frame_mark = 1'b1;
        end
        idle(12);
        settle();
        chk("R7", "short pulse ignored", bclk_en, 1'b0);
    endtask

    task automatic t_warm();
        for (int i = 0; i < WARM; i++) begin
            @(negedge clk);
            frame_mark = 1'b1;
        end
        @(negedge clk);
        frame_mark = 1'b0;
        settle();
        settle();
        chk("R6", "still stopped two edges after release", bclk_en, 1'b0);
        settle();
        chk("R6", "clock restarted on third edge", bclk_en, 1'b1);
        chk("R6", "din_en restarted", din_en, 1'b1);
        chk("R9", "ready low after wake", codec_ready, 1'b0);
        chk("R10", "no clear on wake", clr_regs, 1'b0);
    endtask

    task automatic t_cold_in_halt();
        @(negedge clk);
        por_n = 1'b0;
        #1;
        chk("R8", "async restart bclk_en", bclk_en, 1'b1);
        chk("R8", "async restart din_en", din_en, 1'b1);
        chk("R8", "ready low on cold reset", codec_ready, 1'b0);
        @(negedge clk);
        por_n = 1'b1;
    endtask

    initial begin
        t_reset();
        idle(2);
        t_ready("R9");
        t_no_halt("R3", mk_frame(3'b111, 1'b1, 7'h26, 16'h1000));
        t_no_halt("R3", mk_frame(3'b011, 1'b0, 7'h26, 16'h1000));
        t_no_halt("R4", mk_frame(3'b111, 1'b0, 7'h26, 16'hEFFF));
        t_no_halt("R1", mk_frame(3'b111, 1'b0, 7'h26, 16'h1000) << 1);
        t_regrst();
        t_halt();
        t_short();
        t_warm();
        idle(3);
        t_ready("R9");
        t_halt();
        t_cold_in_halt();
        idle(2);
        t_ready("R9");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule